// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a liveness signal that a processor toggles while its software runs. Every rising or falling transition on that signal restarts an internal cycle counter. If the counter runs a full window with no transition, the block drives its active-low timeout output low. The output stays low until something clears the counter. A clear can be a new transition, the reset-active flag from the system reset generator, or a flag saying the liveness input is floating. A floating input means the watchdog is disabled.

A supply-good flag gates the output directly. When it reports a low-line condition, the timeout output goes low in the same cycle. When the supply recovers, the output goes high again with no minimum pulse width, unless a timeout is still pending. The window is set by the parameters `CLK_KHZ` and `WINDOW_MS`, and holds `CLK_KHZ*WINDOW_MS` clock cycles. The default is 1.6 s at 200 MHz. The raw input passes through two flops before edge detection. The three flags are treated as synchronous to `clk`.

Top module: `wdog_edge_timer`

## Requirements
- R1: With no clear condition, the timeout output goes low after the window. Counting the posedge that samples a new input level as posedge 1, `wdo_n` is low after posedge LIMIT+3, and high after posedge LIMIT+2. This holds whether the input rests high or low.
- R2: A rising edge on `wdi` clears the timer, and so does a falling edge. The clear takes effect at the third posedge after the level change, because of two synchroniser flops and one previous-value flop.
- R3: While `rst_active` is 1, the timer is held cleared. After it drops, the first posedge without it is counted as posedge 1, and `wdo_n` falls after posedge LIMIT.
- R4: While `wdi_float` is 1, the timer is held cleared and `wdo_n` never falls from a timeout.
- R5: Once a timeout has occurred, `wdo_n` stays low until a clear condition is seen.
- R6: When `supply_ok` is 0, `wdo_n` is 0 in the same cycle, with no clock edge needed.
- R7: When `supply_ok` returns to 1 and no timeout is pending, `wdo_n` is 1 in the same cycle.
- R8: When a clear arrives after a timeout and `supply_ok` is 1, `wdo_n` returns high right after the posedge that takes the clear.
- R9: If `wdi` toggles steadily every G cycles, `wdo_n` never falls when G ≤ LIMIT. When G = LIMIT+1 it falls.
- R10: While `rst_n` is 0, the block is in its reset state, and `wdo_n` equals `supply_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| wdi | input | 1 | Liveness input from the processor, asynchronous |
| wdi_float | input | 1 | 1 = input floating; watchdog disabled and timer cleared |
| rst_active | input | 1 | 1 = system reset asserted; timer held cleared |
| supply_ok | input | 1 | 1 = supply above threshold; 0 forces the output low |
| wdo_n | output | 1 | Active-low timeout output |

## Verification
Two functions can fall in the same cycle: the clear that ends a timeout, and the supply-good gate on the output. The bench produces this overlap by lowering `supply_ok` and toggling `wdi` in the same low clock phase while a timeout is pending. The output must stay low through the clear, because of the supply gate. It must then rise the moment the supply returns, since the timeout has already been cleared. A second overlap is an edge landing on the very cycle the count would expire. The toggle-period sweep probes this at G = LIMIT, where no timeout may appear, and at G = LIMIT+1, where one must.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // State of the input synchroniser and edge detector
    typedef struct packed {
        logic meta;   // first capture stage
        logic stab;   // second, stable stage
        logic last;   // previous stable sample
    } wdog_sync_t;

    // Window length in cycles from clock rate and window time
    function automatic int unsigned window_cycles(input int unsigned khz,
                                                  input int unsigned ms);
        return khz * ms;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic edge_seen
);

    wdog_sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_in;
        st_d.stab = st_q.meta;
        st_d.last = st_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // rising or falling: any difference from the previous stable sample
    assign edge_seen = st_q.stab ^ st_q.last;

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          exp;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
            st_d.exp = 1'b0;
        end else begin
            if (st_q.cnt != LIM_C) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LIM_M1) st_d.exp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.exp;

    // counter saturates at the window length
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM_C);

    // a timeout persists until a clear is seen
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);

    // the count only advances by one or stays saturated
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && st_q.cnt != LIM_C) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 200_000,
    parameter int unsigned WINDOW_MS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi,
    input  logic wdi_float,
    input  logic rst_active,
    input  logic supply_ok,
    output logic wdo_n
);

    localparam int unsigned LIMIT = window_cycles(CLK_KHZ, WINDOW_MS);

    logic edge_seen;
    logic clear;
    logic expired;

    wdog_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (wdi),
        .edge_seen(edge_seen)
    );

    assign clear = edge_seen | rst_active | wdi_float;

    wdog_count #(.LIMIT(LIMIT)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .expired(expired)
    );

    // output follows supply with no pulse stretching
    assign wdo_n = supply_ok & ~expired;

    assert_edge_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (wdo_n || !supply_ok));

    assert_rst_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> (wdo_n || !supply_ok));

    assert_float_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdi_float |=> (wdo_n || !supply_ok));

    assert_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdo_n && clear) |=> (wdo_n || !supply_ok));

endmodule

// File: tb/tb_wdog_edge_timer.sv
`timescale 1ns/1ps
module tb_wdog_edge_timer;

    localparam int LIMIT = 8;

    logic clk = 1'b0;
    logic rst_n, wdi, wdi_float, rst_active, supply_ok;
    logic wdo_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdog_edge_timer #(.CLK_KHZ(1), .WINDOW_MS(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .wdi(wdi), .wdi_float(wdi_float),
        .rst_active(rst_active), .supply_ok(supply_ok), .wdo_n(wdo_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // posedges until wdo_n reads low, capped
    task automatic latency(output int n);
        n = 0;
        for (int i = 0; i < 4*LIMIT; i++) begin
            step();
            n++;
            if (!wdo_n) return;
        end
        n = -1;
    endtask

    initial begin
        #(200_000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        bit fell;
        rst_n = 0; wdi = 0; wdi_float = 0; rst_active = 1; supply_ok = 1;
        @(negedge clk); @(negedge clk);
        check(wdo_n == 1, "R10 reset state", wdo_n, 1);
        supply_ok = 0; #1;
        check(wdo_n == 0, "R10 reset follows supply", wdo_n, 0);
        supply_ok = 1; #1;
        rst_n = 1;
        step(); step();
        // R3: release reset-active, timeout after LIMIT posedges
        rst_active = 0;
        latency(n);
        check(n == LIMIT, "R3 latency after reset release", n, LIMIT);
        // R5: stays low
        for (int i = 0; i < 2*LIMIT; i++) begin
            step();
            check(wdo_n == 0, "R5 sticky timeout", wdo_n, 0);
        end
        // R2/R8 rising edge, then R1 with input held high
        wdi = 1;
        step(); step();
        check(wdo_n == 0, "R2 still low before clear", wdo_n, 0);
        step();
        check(wdo_n == 1, "R8 high after clear (rising)", wdo_n, 1);
        // R6/R7 while no timeout pending
        supply_ok = 0; #1;
        check(wdo_n == 0, "R6 low-line forces low", wdo_n, 0);
        supply_ok = 1; #1;
        check(wdo_n == 1, "R7 immediate recovery", wdo_n, 1);
        latency(n);
        check(n == LIMIT, "R1 held high", n + 3, LIMIT + 3);
        // falling edge, R1 held low
        wdi = 0;
        step(); step(); step();
        check(wdo_n == 1, "R8 high after clear (falling)", wdo_n, 1);
        latency(n);
        check(n == LIMIT, "R1 held low", n + 3, LIMIT + 3);
        // Same-cycle: supply low together with clearing edge
        supply_ok = 0; wdi = 1;
        step(); step(); step();
        check(wdo_n == 0, "R6 supply gate during clear", wdo_n, 0);
        supply_ok = 1; #1;
        check(wdo_n == 1, "R7 recovery after cleared timeout", wdo_n, 1);
        latency(n);
        check(n == LIMIT, "R1 window after overlap", n + 3, LIMIT + 3);
        // R4: float clears timeout next clock and holds off
        wdi_float = 1;
        step();
        check(wdo_n == 1, "R4 float clears", wdo_n, 1);
        fell = 0;
        for (int i = 0; i < 3*LIMIT; i++) begin
            step();
            if (!wdo_n) fell = 1;
        end
        check(!fell, "R4 no timeout while floating", fell, 0);
        wdi_float = 0;
        latency(n);
        check(n == LIMIT, "R4 window after float release", n, LIMIT);
        // R3: reset-active clears a pending timeout
        rst_active = 1;
        step();
        check(wdo_n == 1, "R3 reset-active clears", wdo_n, 1);
        fell = 0;
        for (int i = 0; i < 3*LIMIT; i++) begin
            step();
            if (!wdo_n) fell = 1;
        end
        check(!fell, "R3 held cleared", fell, 0);
        // R9: toggle period sweep
        for (int g = 1; g <= LIMIT + 1; g++) begin
            rst_active = 1;
            step(); step();
            rst_active = 0;
            fell = 0;
            for (int c = 0; c < 4*(LIMIT + 1); c++) begin
                if (c % g == 0) wdi = ~wdi;
                step();
                if (!wdo_n) fell = 1;
            end
            check(fell == (g > LIMIT), $sformatf("R9 period %0d", g), fell, g > LIMIT);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule